// File: doc/BRIEF.md
# ECC Step Status Evaluator

After a page read, the BCH decoder leaves one status word per ECC step. This block takes those words one at a time, step 0 first, and turns them into a verdict for the whole page. The verdict has five parts: a result code, the largest bit-flip count seen in any step, a bitmap marking the steps that decoded cleanly, the sum of all corrected bits, and the two user bytes carried by each step.

A page starts with a one-cycle `start` pulse, which also latches the number of steps, the scrambling setting and the ECC strength. The status words then arrive with `word_valid`. The last step's word counts only once its completion flag is set. Until then the host can keep offering it, and each offer without the flag is dropped. When the completed last word is accepted, `done` pulses for one cycle. The outputs then hold their values until the next `start`.

When scrambling is on, an erased page can look uncorrectable to the decoder. A step whose decode failed, but whose zero-bit count is below the configured strength, is therefore classified as erased rather than failed. Such a step is left out of the success bitmap. That bitmap lets later logic test each failed chunk for erasure separately.

Top module: `ecc_step_eval`

## Requirements
- R1: After reset, `busy`, `done`, `result`, `max_flips`, `ok_map` and `corr_total` are all zero.
- R2: A `start` pulse clears `result`, `max_flips`, `ok_map`, `corr_total` and `user_bytes`, and sets `busy`. A word offered while `busy` is low is ignored.
- R3: A step is correctable when its error count (bits 29:24) is not 0x3F. Its error count is then added to `corr_total`, `max_flips` rises to that count if it is larger, and bit k of `ok_map` is set for step k.
- R4: A step whose error count is 0x3F is classified as erased when `scramble_en` is 1 and its zero count (bits 21:16) is strictly less than `strength`. Its zero count is added to `corr_total` and to the running maximum, `result` becomes 2'b01, and its `ok_map` bit stays 0.
- R5: Every other step whose error count is 0x3F sets `result` to 2'b10 (failed) and adds nothing.
- R6: `result` reads 2'b00 (ok) unless some step was uncorrectable. When several steps are uncorrectable, the one latest in step order sets the code. Correctable steps leave the code unchanged.
- R7: A last-step word whose completion flag (bit 31) is 0 is dropped and changes nothing. `done` rises in the cycle after the completed last word is accepted, lasts exactly one cycle, and `busy` is low while `done` is high.
- R8: Words for steps before the last are accepted whatever the value of bit 31.
- R9: Bits 15:0 of step k's word appear on `user_bytes[16k+15:16k]`.
- R10: `num_steps` may be any value from 1 to MAX_STEPS. Steps at or above `num_steps` never set an `ok_map` bit.
- R11: Between `done` and the next `start`, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new page and latch its configuration |
| num_steps | input | STEP_W (4) | Number of ECC steps in the page, 1..MAX_STEPS |
| scramble_en | input | 1 | Scrambling on, which enables erased-page reclassification |
| strength | input | 6 | ECC strength used as the erased-page threshold |
| word_valid | input | 1 | `word_in` holds the next step's status word |
| word_in | input | 64 | Per-step status word |
| busy | output | 1 | A page is being evaluated |
| done | output | 1 | One-cycle pulse when the page verdict is ready |
| result | output | 2 | 00 ok, 01 erased, 10 failed |
| max_flips | output | 6 | Largest per-step bit-flip count |
| ok_map | output | MAX_STEPS (8) | One bit per cleanly decoded step |
| corr_total | output | TOT_W (10) | Sum of corrected bits |
| user_bytes | output | 16*MAX_STEPS (128) | User bytes, 16 bits per step |

## Verification
The bench keeps the default MAX_STEPS of 8 and varies `num_steps` from page to page across 1..8. This covers the one-step page, where the first word is also the last, and the full eight-step page, where the largest totals occur and the top `ok_map` and `user_bytes` lanes are used. Strengths are drawn over the whole 6-bit range, so zero counts land on both sides of the threshold, including exactly on it. Last-step words are offered first without the completion flag, so the polling path is exercised on pages of every length.

// File: rtl/ecc_eval_pkg.sv
package ecc_eval_pkg;

  localparam int CNT_W = 6;
  localparam logic [CNT_W-1:0] UNCORRECTABLE = 6'h3F;

  typedef enum logic [1:0] {
    RES_OK     = 2'b00,
    RES_ERASED = 2'b01,
    RES_FAIL   = 2'b10
  } res_e;

  typedef enum logic [1:0] {
    CL_GOOD   = 2'b00,
    CL_ERASED = 2'b01,
    CL_BAD    = 2'b10
  } cls_e;

  function automatic logic [CNT_W-1:0] err_field(input logic [31:0] w);
    return w[29:24];
  endfunction

  function automatic logic [CNT_W-1:0] zero_field(input logic [31:0] w);
    return w[21:16];
  endfunction

  function automatic logic complete_flag(input logic [31:0] w);
    return w[31];
  endfunction

endpackage

// File: rtl/ecc_step_classify.sv
module ecc_step_classify
  import ecc_eval_pkg::*;
(
  input  logic [31:0]      status,
  input  logic             scramble_en,
  input  logic [CNT_W-1:0] strength,
  output cls_e             cls,
  output logic [CNT_W-1:0] flips
);

  logic [CNT_W-1:0] errs;
  logic [CNT_W-1:0] zeros;

  assign errs  = err_field(status);
  assign zeros = zero_field(status);

  always_comb begin
    if (errs != UNCORRECTABLE) begin
      cls   = CL_GOOD;
      flips = errs;
    end else if (scramble_en && (zeros < strength)) begin
      cls   = CL_ERASED;
      flips = zeros;
    end else begin
      cls   = CL_BAD;
      flips = '0;
    end
  end

endmodule

// File: rtl/ecc_page_accum.sv
module ecc_page_accum
  import ecc_eval_pkg::*;
#(
  parameter int MAX_STEPS = 8,
  parameter int STEP_W    = 4,
  parameter int TOT_W     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 acc,
  input  logic [STEP_W-1:0]    step_idx,
  input  cls_e                 cls,
  input  logic [CNT_W-1:0]     flips,
  output logic [1:0]           result,
  output logic [CNT_W-1:0]     max_flips,
  output logic [MAX_STEPS-1:0] ok_map,
  output logic [TOT_W-1:0]     corr_total
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= RES_OK;
      max_flips  <= '0;
      corr_total <= '0;
    end else if (clear) begin
      result     <= RES_OK;
      max_flips  <= '0;
      corr_total <= '0;
    end else if (acc) begin
      corr_total <= corr_total + TOT_W'(flips);
      if (flips > max_flips) max_flips <= flips;
      if (cls == CL_ERASED)   result <= RES_ERASED;
      else if (cls == CL_BAD) result <= RES_FAIL;
    end
  end

  for (genvar k = 0; k < MAX_STEPS; k++) begin : g_ok
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ok_map[k] <= 1'b0;
      else if (clear)  ok_map[k] <= 1'b0;
      else if (acc && (cls == CL_GOOD) && (step_idx == STEP_W'(k)))
        ok_map[k] <= 1'b1;
    end
  end

endmodule

// File: rtl/ecc_user_capture.sv
module ecc_user_capture #(
  parameter int MAX_STEPS = 8,
  parameter int STEP_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    acc,
  input  logic [STEP_W-1:0]       step_idx,
  input  logic [15:0]             user_in,
  output logic [16*MAX_STEPS-1:0] user_bytes
);

  for (genvar k = 0; k < MAX_STEPS; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     user_bytes[16*k +: 16] <= '0;
      else if (clear) user_bytes[16*k +: 16] <= '0;
      else if (acc && (step_idx == STEP_W'(k)))
        user_bytes[16*k +: 16] <= user_in;
    end
  end

endmodule

// File: rtl/ecc_step_eval.sv
module ecc_step_eval
  import ecc_eval_pkg::*;
#(
  parameter  int MAX_STEPS = 8,
  localparam int STEP_W    = $clog2(MAX_STEPS + 1),
  localparam int TOT_W     = CNT_W + $clog2(MAX_STEPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [STEP_W-1:0]       num_steps,
  input  logic                    scramble_en,
  input  logic [CNT_W-1:0]        strength,
  input  logic                    word_valid,
  input  logic [63:0]             word_in,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              result,
  output logic [CNT_W-1:0]        max_flips,
  output logic [MAX_STEPS-1:0]    ok_map,
  output logic [TOT_W-1:0]        corr_total,
  output logic [16*MAX_STEPS-1:0] user_bytes
);

  logic [STEP_W-1:0] step_idx;
  logic [STEP_W-1:0] n_cfg;
  logic              scr_cfg;
  logic [CNT_W-1:0]  str_cfg;

  logic [31:0]       low_word;
  logic              unused_hi;
  logic              is_last;
  logic              acc;
  logic              finish;
  logic              step_bad;
  cls_e              cls;
  logic [CNT_W-1:0]  flips;

  assign low_word  = word_in[31:0];
  assign unused_hi = ^{word_in[63:32], word_in[30], word_in[23:22]};

  assign is_last  = (step_idx == n_cfg - STEP_W'(1));
  assign acc      = busy && word_valid && !start &&
                    (!is_last || complete_flag(low_word));
  assign finish   = acc && is_last;
  assign step_bad = (cls != CL_GOOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_idx <= '0;
      n_cfg    <= STEP_W'(1);
      scr_cfg  <= 1'b0;
      str_cfg  <= '0;
    end else begin
      done <= finish;
      if (start) begin
        busy     <= 1'b1;
        step_idx <= '0;
        n_cfg    <= num_steps;
        scr_cfg  <= scramble_en;
        str_cfg  <= strength;
      end else if (acc) begin
        step_idx <= step_idx + STEP_W'(1);
        if (is_last) busy <= 1'b0;
      end
    end
  end

  ecc_step_classify u_classify (
    .status      (low_word),
    .scramble_en (scr_cfg),
    .strength    (str_cfg),
    .cls         (cls),
    .flips       (flips)
  );

  ecc_page_accum #(
    .MAX_STEPS (MAX_STEPS),
    .STEP_W    (STEP_W),
    .TOT_W     (TOT_W)
  ) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .acc        (acc),
    .step_idx   (step_idx),
    .cls        (cls),
    .flips      (flips),
    .result     (result),
    .max_flips  (max_flips),
    .ok_map     (ok_map),
    .corr_total (corr_total)
  );

  ecc_user_capture #(
    .MAX_STEPS (MAX_STEPS),
    .STEP_W    (STEP_W)
  ) u_user (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .acc        (acc),
    .step_idx   (step_idx),
    .user_in    (low_word[15:0]),
    .user_bytes (user_bytes)
  );

endmodule

// File: rtl/ecc_step_eval_chk.sv
module ecc_step_eval_chk #(
  parameter int MAX_STEPS = 8,
  parameter int TOT_W     = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 word_valid,
  input logic                 flag_bit,
  input logic                 is_last,
  input logic                 acc,
  input logic                 step_bad,
  input logic [1:0]           result,
  input logic [5:0]           max_flips,
  input logic [MAX_STEPS-1:0] ok_map,
  input logic [TOT_W-1:0]     corr_total
);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && ok_map == '0 && corr_total == '0 &&
               result == 2'b00 && max_flips == '0));

  a_r4_bad_step_no_ok_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_bad) |=> (ok_map == $past(ok_map)));

  a_r7_incomplete_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && word_valid && is_last && !flag_bit)
      |=> (!done && $stable(corr_total) && $stable(ok_map)));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(corr_total) && $stable(result) &&
                           $stable(ok_map) && $stable(max_flips)));

endmodule

bind ecc_step_eval ecc_step_eval_chk #(
  .MAX_STEPS (MAX_STEPS),
  .TOT_W     (TOT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .word_valid (word_valid),
  .flag_bit   (word_in[31]),
  .is_last    (is_last),
  .acc        (acc),
  .step_bad   (step_bad),
  .result     (result),
  .max_flips  (max_flips),
  .ok_map     (ok_map),
  .corr_total (corr_total)
);

// File: tb/test_ecc_step_eval.sv
`timescale 1ns/1ps
module test_ecc_step_eval;

  localparam int MS = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   num_steps = 4'd1;
  logic         scramble_en = 1'b0;
  logic [5:0]   strength = '0;
  logic         word_valid = 1'b0;
  logic [63:0]  word_in = '0;
  logic         busy, done;
  logic [1:0]   result;
  logic [5:0]   max_flips;
  logic [MS-1:0] ok_map;
  logic [9:0]   corr_total;
  logic [16*MS-1:0] user_bytes;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [63:0] pw [MS];
  int          pn;
  bit          pscr;
  int          pstr;

  always #4 clk = ~clk;

  ecc_step_eval i_ecc_step_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .num_steps(num_steps),
    .scramble_en(scramble_en), .strength(strength), .word_valid(word_valid),
    .word_in(word_in), .busy(busy), .done(done), .result(result),
    .max_flips(max_flips), .ok_map(ok_map), .corr_total(corr_total),
    .user_bytes(user_bytes)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit cmpl, input int e, input int z, input int u);
    logic [63:0] w;
    w = {$urandom(), $urandom()};
    w[31] = cmpl;
    w[29:24] = 6'(e);
    w[21:16] = 6'(z);
    w[15:0] = 16'(u);
    return w;
  endfunction

  // Expected page verdict, restated from R3..R6
  task automatic expect_page(output logic [1:0] r, output int mx,
                             output logic [MS-1:0] m, output int tot);
    r = 2'b00; mx = 0; m = '0; tot = 0;
    for (int k = 0; k < pn; k++) begin
      int e, z;
      e = int'(pw[k][29:24]);
      z = int'(pw[k][21:16]);
      if (e < 63) begin
        tot += e; if (e > mx) mx = e; m[k] = 1'b1;
      end else if (pscr && z < pstr) begin
        tot += z; if (z > mx) mx = z; r = 2'b01;
      end else begin
        r = 2'b10;
      end
    end
  endtask

  task automatic run_page(input int polls);
    logic [1:0] er; int emx; logic [MS-1:0] em; int etot;
    @(negedge clk);
    start = 1'b1; num_steps = 4'(pn); scramble_en = pscr; strength = 6'(pstr);
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R2 cleared total", corr_total, 0);
    for (int k = 0; k < pn - 1; k++) begin
      word_valid = 1'b1; word_in = pw[k];
      @(negedge clk);
    end
    for (int p = 0; p < polls; p++) begin
      word_valid = 1'b1; word_in = pw[pn-1]; word_in[31] = 1'b0;
      @(negedge clk);
      check("R7 no done while incomplete", done, 0);
      check("R7 busy while incomplete", busy, 1);
    end
    word_valid = 1'b1; word_in = pw[pn-1]; word_in[31] = 1'b1;
    pw[pn-1][31] = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    expect_page(er, emx, em, etot);
    check("R7 done pulse", done, 1);
    check("R7 busy low at done", busy, 0);
    check("R6 result code", result, er);
    check("R3 max flips", max_flips, emx);
    check("R10 ok map", ok_map, em);
    check("R4 corrected total", corr_total, etot);
    for (int k = 0; k < pn; k++)
      check("R9 user bytes", user_bytes[16*k +: 16], pw[k][15:0]);
    @(negedge clk);
    check("R7 done single cycle", done, 0);
    // R2/R11: word offered while idle has no effect
    word_valid = 1'b1; word_in = mk(1, 3, 0, 16'h1234);
    @(negedge clk);
    word_valid = 1'b0;
    @(negedge clk);
    check("R11 total held", corr_total, etot);
    check("R11 map held", ok_map, em);
    check("R2 idle word ignored", user_bytes[15:0], pw[0][15:0]);
  endtask

  initial begin
    void'($urandom(20240611));
    repeat (3) @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 result reset", result, 0);
    check("R1 map reset", ok_map, 0);
    check("R1 total reset", corr_total, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: clean eight-step page, maximum correctable counts
    pn = 8; pscr = 0; pstr = 8;
    for (int k = 0; k < 8; k++) pw[k] = mk(k % 2, 62, 0, 16'hA000 + k);
    run_page(0);
    // R6: failed then erased -> erased wins
    pn = 3; pscr = 1; pstr = 10;
    pw[0] = mk(0, 63, 40, 16'h0101); pw[1] = mk(1, 63, 4, 16'h0202); pw[2] = mk(1, 2, 0, 16'h0303);
    run_page(2);
    // R5: erased then failed -> failed wins
    pw[0] = mk(1, 63, 3, 16'h1111); pw[1] = mk(1, 5, 0, 16'h2222); pw[2] = mk(1, 63, 50, 16'h3333);
    run_page(1);
    // R4: zero count equal to strength is not erased
    pn = 1; pscr = 1; pstr = 7;
    pw[0] = mk(1, 63, 7, 16'hBEEF);
    run_page(0);
    // R5: scrambling off never reclassifies
    pscr = 0;
    pw[0] = mk(1, 63, 0, 16'hCAFE);
    run_page(3);
    // R8: single erased step
    pscr = 1;
    pw[0] = mk(1, 63, 6, 16'hF00D);
    run_page(0);

    // Random pages
    for (int t = 0; t < 40; t++) begin
      pn = 1 + int'($urandom() % MS);
      pscr = $urandom() % 2;
      pstr = int'($urandom() % 64);
      for (int k = 0; k < pn; k++) begin
        if ($urandom() % 10 < 6) pw[k] = mk($urandom() % 2, int'($urandom() % 63), int'($urandom() % 64), int'($urandom() % 65536));
        else pw[k] = mk($urandom() % 2, 63, int'($urandom() % 64), int'($urandom() % 65536));
      end
      run_page(int'($urandom() % 3));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule